// File: doc/BRIEF.md
# Real-mode interrupt entry sequencer

This block sits next to a small processor core and, at every instruction boundary, decides whether control must pass to an interrupt handler. Requests come from four groups. The first is a software request from the core: an explicit type number, an overflow-conditional request, or a failed range check. The others are a qualified rising edge on the non-maskable input, a level request that the interrupt-enable flag gates, and the single-step trap flag. For the level request the block first collects an 8-bit type number with a two-pulse acknowledge exchange.

Once a request is taken, the block saves the flags, code segment and instruction pointer on the stack and reads the two-word vector at type×4. It then hands the core a new instruction pointer, code segment, stack pointer and flag word, with interrupt enable and trap cleared. On a return request it reads back instruction pointer, code segment and flags from the stack. All memory traffic uses a single valid/ready port with one request in flight.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, mem_valid, inta_o and upd_valid are all 0.
- R2: Requests are sampled only in a cycle where insn_done is 1 and the block is idle (busy 0); insn_done while busy has no effect. The winner is chosen in this order: software group, pending NMI, INTR, trap. Within the software group the order is sw_req (type sw_type), then into_req with overflow (type 4), then bound_req (type 5).
- R3: into_req with the overflow flag (cur_flags bit 11) at 0 starts no sequence and produces no memory access or update.
- R4: The NMI input becomes pending only on a 0-to-1 transition that follows at least two consecutive sampled cycles at 0. A pending NMI is taken as type 2 whatever the interrupt-enable flag holds.
- R5: A pending NMI stays pending until it is taken, and further edges before that are merged into the same single service.
- R6: INTR is level-sensitive and is ignored while the interrupt-enable flag (cur_flags bit 9) is 0.
- R7: For INTR, inta_o gives two one-cycle pulses with exactly one low cycle between them, and the type number is taken from ack_data during the second pulse.
- R8: Entry writes three 16-bit words in this order: flags to SS×16+(SP−2), CS to SS×16+(SP−4), IP to SS×16+(SP−6). Offsets wrap within 16 bits, and the sum wraps within 20 bits.
- R9: Entry then reads the new IP at type×4 and the new CS at type×4+2. It pulses upd_valid with those values, SP−6, and the saved flags with bits 9 (interrupt enable) and 8 (trap) cleared.
- R10: iret_req at a boundary takes precedence over every interrupt request. The block reads IP at SS×16+SP, CS at +2 and flags at +4, then pulses upd_valid with those values and SP+6.
- R11: A memory request keeps mem_valid, mem_we, mem_addr and mem_wdata stable until mem_ready is seen.
- R12: With no higher request, a trap flag (cur_flags bit 8) at 1 is taken as type 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction-boundary strobe |
| iret_req | input | 1 | Return sequence requested at this boundary |
| sw_req | input | 1 | Software interrupt with explicit type |
| sw_type | input | 8 | Type for sw_req |
| into_req | input | 1 | Overflow-conditional request (type 4) |
| bound_req | input | 1 | Range check failed (type 5) |
| nmi_in | input | 1 | Non-maskable request, edge qualified |
| intr_in | input | 1 | Maskable level request |
| inta_o | output | 1 | Acknowledge pulses for INTR |
| ack_data | input | 8 | Type number bus during acknowledge |
| cur_flags | input | 16 | Core flag word |
| cur_cs | input | 16 | Core code segment |
| cur_ip | input | 16 | Return instruction pointer |
| cur_ss | input | 16 | Stack segment |
| cur_sp | input | 16 | Stack pointer |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or completes the request |
| busy | output | 1 | Sequence in progress |
| upd_valid | output | 1 | One-cycle strobe: load the upd_* values |
| upd_ip | output | 16 | New instruction pointer |
| upd_cs | output | 16 | New code segment |
| upd_sp | output | 16 | New stack pointer |
| upd_flags | output | 16 | New flag word |

## Verification
Every source is tried alone, which shows that each maps to its type. Stacked combinations of software, NMI, INTR and trap are presented over successive boundaries, which shows the priority order and that lower requests survive until served. Masked and null cases separate "taken" from "ignored": INTR with interrupt enable clear, conditional overflow with the flag clear, an NMI rise after a single low cycle, and a boundary strobe during a busy sequence. Different data is placed on the type bus for each acknowledge pulse, so sampling on the wrong pulse is caught. Stack pointers near zero exercise offset wrap, and a stalling ready pattern exercises request stability.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int DW          = 16,
  parameter int AW          = 20,
  parameter int TW          = 8,
  parameter int IF_BIT      = 9,
  parameter int TF_BIT      = 8,
  parameter int OF_BIT      = 11,
  parameter int NMI_LOW_MIN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_done,
  input  logic          iret_req,
  input  logic          sw_req,
  input  logic [TW-1:0] sw_type,
  input  logic          into_req,
  input  logic          bound_req,
  input  logic          nmi_in,
  input  logic          intr_in,
  output logic          inta_o,
  input  logic [TW-1:0] ack_data,
  input  logic [DW-1:0] cur_flags,
  input  logic [DW-1:0] cur_cs,
  input  logic [DW-1:0] cur_ip,
  input  logic [DW-1:0] cur_ss,
  input  logic [DW-1:0] cur_sp,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          upd_valid,
  output logic [DW-1:0] upd_ip,
  output logic [DW-1:0] upd_cs,
  output logic [DW-1:0] upd_sp,
  output logic [DW-1:0] upd_flags
);
  localparam int LCW = $clog2(NMI_LOW_MIN + 1);
  localparam int WB  = DW / 8;
  localparam logic [DW-1:0] W1 = DW'(WB);
  localparam logic [DW-1:0] W2 = DW'(2 * WB);
  localparam logic [DW-1:0] W3 = DW'(3 * WB);
  localparam logic [DW-1:0] MASK = (DW'(1) << IF_BIT) | (DW'(1) << TF_BIT);
  localparam logic [TW-1:0] T_TRAP = TW'(1);
  localparam logic [TW-1:0] T_NMI  = TW'(2);
  localparam logic [TW-1:0] T_OVF  = TW'(4);
  localparam logic [TW-1:0] T_BND  = TW'(5);

  typedef enum logic [3:0] {
    S_IDLE, S_ACK1, S_GAP, S_ACK2, S_PF, S_PC, S_PI,
    S_VI, S_VC, S_RI, S_RC, S_RF, S_DONE
  } st_t;

  st_t st;
  logic [TW-1:0] typ;
  logic [DW-1:0] s_flags, s_cs, s_ip, s_ss, s_sp;
  logic ret_mode;
  logic nmi_prev, nmi_pend;
  logic [LCW-1:0] low_cnt;

  wire nmi_edge = nmi_in && !nmi_prev && (low_cnt >= LCW'(NMI_LOW_MIN));
  wire ovf_hit  = into_req && cur_flags[OF_BIT];
  wire sw_hit   = sw_req || ovf_hit || bound_req;
  wire intr_hit = intr_in && cur_flags[IF_BIT];
  wire trap_hit = cur_flags[TF_BIT];
  wire accept   = (st == S_IDLE) && insn_done;
  wire nmi_take = accept && !iret_req && !sw_hit && nmi_pend;
  wire take_any = sw_hit || nmi_pend || intr_hit || trap_hit;
  wire [TW-1:0] sw_sel = sw_req ? sw_type : (ovf_hit ? T_OVF : T_BND);

  assign busy      = (st != S_IDLE);
  assign inta_o    = (st == S_ACK1) || (st == S_ACK2);
  assign upd_valid = (st == S_DONE);
  assign mem_valid = (st >= S_PF) && (st <= S_RF);
  assign mem_we    = (st == S_PF) || (st == S_PC) || (st == S_PI);

  logic [DW-1:0] off, sp_off;
  logic [DW+3:0] seg_base;
  always_comb begin
    case (st)
      S_PF:    off = -W1;
      S_PC:    off = -W2;
      S_PI:    off = -W3;
      S_RC:    off = W1;
      S_RF:    off = W2;
      default: off = '0;
    endcase
    sp_off   = s_sp + off;
    seg_base = {s_ss, 4'b0000};
    if (st == S_VI || st == S_VC)
      mem_addr = AW'({typ, 2'b00}) + ((st == S_VC) ? AW'(WB) : AW'(0));
    else
      mem_addr = AW'(seg_base) + AW'(sp_off);
    case (st)
      S_PF:    mem_wdata = s_flags;
      S_PC:    mem_wdata = s_cs;
      S_PI:    mem_wdata = s_ip;
      default: mem_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      low_cnt  <= '0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      if (nmi_in) low_cnt <= '0;
      else if (low_cnt < LCW'(NMI_LOW_MIN)) low_cnt <= low_cnt + 1'b1;
      if (nmi_edge) nmi_pend <= 1'b1;
      else if (nmi_take) nmi_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      typ       <= '0;
      ret_mode  <= 1'b0;
      s_flags   <= '0;
      s_cs      <= '0;
      s_ip      <= '0;
      s_ss      <= '0;
      s_sp      <= '0;
      upd_ip    <= '0;
      upd_cs    <= '0;
      upd_sp    <= '0;
      upd_flags <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept && (iret_req || take_any)) begin
          s_flags  <= cur_flags;
          s_cs     <= cur_cs;
          s_ip     <= cur_ip;
          s_ss     <= cur_ss;
          s_sp     <= cur_sp;
          ret_mode <= iret_req;
          if (iret_req) st <= S_RI;
          else if (sw_hit) begin typ <= sw_sel; st <= S_PF; end
          else if (nmi_pend) begin typ <= T_NMI; st <= S_PF; end
          else if (intr_hit) st <= S_ACK1;
          else begin typ <= T_TRAP; st <= S_PF; end
        end
        S_ACK1: st <= S_GAP;
        S_GAP:  st <= S_ACK2;
        S_ACK2: begin typ <= ack_data; st <= S_PF; end
        S_PF: if (mem_ready) st <= S_PC;
        S_PC: if (mem_ready) st <= S_PI;
        S_PI: if (mem_ready) st <= S_VI;
        S_VI: if (mem_ready) begin upd_ip <= mem_rdata; st <= S_VC; end
        S_VC: if (mem_ready) begin
          upd_cs    <= mem_rdata;
          upd_flags <= s_flags & ~MASK;
          upd_sp    <= s_sp - W3;
          st        <= S_DONE;
        end
        S_RI: if (mem_ready) begin upd_ip <= mem_rdata; st <= S_RC; end
        S_RC: if (mem_ready) begin upd_cs <= mem_rdata; st <= S_RF; end
        S_RF: if (mem_ready) begin
          upd_flags <= mem_rdata;
          upd_sp    <= s_sp + W3;
          st        <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int DW     = 16,
  parameter int AW     = 20,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          inta_o,
  input logic          busy,
  input logic          upd_valid,
  input logic [DW-1:0] upd_flags,
  input logic          ret_mode,
  input logic          nmi_in,
  input logic          nmi_pend,
  input logic          nmi_take
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_INTA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |=> !inta_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !inta_o && !upd_valid); // R2
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !ret_mode |-> !upd_flags[IF_BIT] && !upd_flags[TF_BIT]); // R9
  AST_NMI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend) |-> $past(nmi_in) && !$past(nmi_in, 2)); // R4
  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend && !nmi_take |=> nmi_pend); // R5
endmodule

bind irq_entry_seq irq_entry_chk #(.DW(DW), .AW(AW), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .inta_o(inta_o),
  .busy(busy), .upd_valid(upd_valid), .upd_flags(upd_flags), .ret_mode(ret_mode),
  .nmi_in(nmi_in), .nmi_pend(nmi_pend), .nmi_take(nmi_take)
);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic insn_done = 0, iret_req = 0, sw_req = 0, into_req = 0, bound_req = 0;
  logic nmi_in = 0, intr_in = 0, mem_ready = 0;
  logic [7:0] sw_type = 0, ack_data = 0;
  logic [15:0] cur_flags = 0, cur_cs = 0, cur_ip = 0, cur_ss = 0, cur_sp = 0, mem_rdata = 0;
  logic inta_o, mem_valid, mem_we, busy, upd_valid;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, upd_ip, upd_cs, upd_sp, upd_flags;

  always #2 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .iret_req(iret_req),
    .sw_req(sw_req), .sw_type(sw_type), .into_req(into_req), .bound_req(bound_req),
    .nmi_in(nmi_in), .intr_in(intr_in), .inta_o(inta_o), .ack_data(ack_data),
    .cur_flags(cur_flags), .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .upd_valid(upd_valid),
    .upd_ip(upd_ip), .upd_cs(upd_cs), .upd_sp(upd_sp), .upd_flags(upd_flags));

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [19:0] q_addr[$];
  logic        q_we[$];
  logic [15:0] q_wd[$];
  logic [15:0] q_uip[$], q_ucs[$], q_usp[$], q_ufl[$];
  int inta_cnt = 0, inta_last = 0, inta_gap = 0;
  logic [7:0] step_type = 0;
  string cur_tag = "R1";

  bit m_prev = 0, m_pend = 0;
  int m_low = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] memf(input logic [19:0] a);
    return (a[15:0] ^ 16'h5A3C) + {12'd0, a[19:16]};
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] o);
    return {seg, 4'b0} + {4'b0, o};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin m_prev <= 0; m_low <= 0; end
    else begin
      if (nmi_in && !m_prev && m_low >= 2) m_pend = 1;
      m_low  <= nmi_in ? 0 : m_low + 1;
      m_prev <= nmi_in;
    end
  end

  always @(negedge clk) begin
    bit rdy;
    cyc++;
    rdy = (cyc % 3) != 1;
    mem_ready = rdy;
    mem_rdata = memf(mem_addr);
    if (rst_n && mem_valid && rdy) begin
      if (q_addr.size() == 0) chk(0, {cur_tag, " unexpected access"}, {12'd0, mem_addr}, 0);
      else begin
        logic [19:0] ea; logic ew; logic [15:0] ed;
        ea = q_addr.pop_front(); ew = q_we.pop_front(); ed = q_wd.pop_front();
        chk(mem_addr == ea, {cur_tag, " addr"}, {12'd0, mem_addr}, {12'd0, ea});
        chk(mem_we == ew, {cur_tag, " we"}, {31'd0, mem_we}, {31'd0, ew});
        if (ew) chk(mem_wdata == ed, {cur_tag, " wdata"}, {16'd0, mem_wdata}, {16'd0, ed});
      end
    end
    if (rst_n && upd_valid) begin
      if (q_uip.size() == 0) chk(0, {cur_tag, " unexpected update"}, {16'd0, upd_ip}, 0);
      else begin
        logic [15:0] a, b, c, d;
        a = q_uip.pop_front(); b = q_ucs.pop_front(); c = q_usp.pop_front(); d = q_ufl.pop_front();
        chk(upd_ip == a, {cur_tag, " upd_ip"}, {16'd0, upd_ip}, {16'd0, a});
        chk(upd_cs == b, {cur_tag, " upd_cs"}, {16'd0, upd_cs}, {16'd0, b});
        chk(upd_sp == c, {cur_tag, " upd_sp"}, {16'd0, upd_sp}, {16'd0, c});
        chk(upd_flags == d, {cur_tag, " upd_flags"}, {16'd0, upd_flags}, {16'd0, d});
      end
    end
    if (rst_n && inta_o) begin
      inta_cnt++;
      if (inta_cnt == 2) inta_gap = cyc - inta_last;
      inta_last = cyc;
      ack_data = (inta_cnt == 1) ? 8'hEE : step_type;
    end
  end

  task automatic expect_entry(input logic [7:0] t);
    logic [15:0] ip, cs;
    q_addr.push_back(phys(cur_ss, cur_sp - 16'd2)); q_we.push_back(1); q_wd.push_back(cur_flags);
    q_addr.push_back(phys(cur_ss, cur_sp - 16'd4)); q_we.push_back(1); q_wd.push_back(cur_cs);
    q_addr.push_back(phys(cur_ss, cur_sp - 16'd6)); q_we.push_back(1); q_wd.push_back(cur_ip);
    q_addr.push_back({10'd0, t, 2'b00}); q_we.push_back(0); q_wd.push_back(0);
    q_addr.push_back({10'd0, t, 2'b00} + 20'd2); q_we.push_back(0); q_wd.push_back(0);
    ip = memf({10'd0, t, 2'b00}); cs = memf({10'd0, t, 2'b00} + 20'd2);
    q_uip.push_back(ip); q_ucs.push_back(cs); q_usp.push_back(cur_sp - 16'd6);
    q_ufl.push_back(cur_flags & ~16'h0300);
  endtask

  task automatic expect_ret();
    logic [19:0] a0, a1, a2;
    a0 = phys(cur_ss, cur_sp); a1 = phys(cur_ss, cur_sp + 16'd2); a2 = phys(cur_ss, cur_sp + 16'd4);
    q_addr.push_back(a0); q_we.push_back(0); q_wd.push_back(0);
    q_addr.push_back(a1); q_we.push_back(0); q_wd.push_back(0);
    q_addr.push_back(a2); q_we.push_back(0); q_wd.push_back(0);
    q_uip.push_back(memf(a0)); q_ucs.push_back(memf(a1)); q_usp.push_back(cur_sp + 16'd6);
    q_ufl.push_back(memf(a2));
  endtask

  // Drives one boundary strobe, predicts the outcome, and checks completion.
  task automatic boundary(input string tag, input bit ir, input bit sw, input logic [7:0] swt,
                          input bit ovf, input bit bnd, input logic [7:0] intr_type);
    int exp_inta;
    cur_tag = tag;
    exp_inta = 0;
    inta_cnt = 0; inta_gap = 0;
    step_type = intr_type;
    @(negedge clk);
    insn_done = 1; iret_req = ir; sw_req = sw; sw_type = swt; into_req = ovf; bound_req = bnd;
    if (ir) expect_ret();
    else if (sw) expect_entry(swt);
    else if (ovf && cur_flags[11]) expect_entry(8'd4);
    else if (bnd) expect_entry(8'd5);
    else if (m_pend) begin expect_entry(8'd2); m_pend = 0; end
    else if (intr_in && cur_flags[9]) begin expect_entry(intr_type); exp_inta = 2; end
    else if (cur_flags[8]) expect_entry(8'd1);
    @(negedge clk);
    insn_done = 0; iret_req = 0; sw_req = 0; into_req = 0; bound_req = 0;
    repeat (40) @(negedge clk);
    chk(q_addr.size() == 0 && q_uip.size() == 0, {tag, " sequence complete"}, q_addr.size(), 0);
    chk(inta_cnt == exp_inta, {tag, " inta pulses"}, inta_cnt, exp_inta);
    if (exp_inta == 2) chk(inta_gap == 2, {tag, " inta spacing"}, inta_gap, 2);
    chk(busy == 0, {tag, " idle after"}, {31'd0, busy}, 0);
  endtask

  task automatic ctx(input logic [15:0] fl, input logic [15:0] sp);
    cur_flags = fl; cur_cs = 16'h1234; cur_ip = 16'hBEEF ^ sp; cur_ss = 16'h2000; cur_sp = sp;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_valid == 0 && inta_o == 0 && upd_valid == 0, "R1 reset idle",
        {28'd0, busy, mem_valid, inta_o, upd_valid}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    ctx(16'h0000, 16'h0100); boundary("R8 sw type", 0, 1, 8'h21, 0, 0, 0);
    ctx(16'h0200, 16'h0004); boundary("R9 sw wrap", 0, 1, 8'hFF, 0, 0, 0);
    ctx(16'h0000, 16'h0200); boundary("R3 into no ovf", 0, 0, 0, 1, 0, 0);
    ctx(16'h0800, 16'h0200); boundary("R2 into ovf", 0, 0, 0, 1, 0, 0);
    ctx(16'h0000, 16'h0300); boundary("R2 bound", 0, 0, 0, 0, 1, 0);
    ctx(16'h0100, 16'h0400); boundary("R12 trap", 0, 0, 0, 0, 0, 0);

    intr_in = 1;
    ctx(16'h0000, 16'h0500); boundary("R6 intr masked", 0, 0, 0, 0, 0, 8'h47);
    ctx(16'h0200, 16'h0500); boundary("R7 intr ack", 0, 0, 0, 0, 0, 8'h47);
    intr_in = 0;

    nmi_in = 0; repeat (3) @(negedge clk); nmi_in = 1; repeat (2) @(negedge clk);
    ctx(16'h0000, 16'h0600); boundary("R4 nmi unmasked", 0, 0, 0, 0, 0, 0);
    ctx(16'h0000, 16'h0600); boundary("R5 nmi cleared", 0, 0, 0, 0, 0, 0);

    nmi_in = 0; @(negedge clk); nmi_in = 1; repeat (2) @(negedge clk);
    ctx(16'h0000, 16'h0700); boundary("R4 nmi short low", 0, 0, 0, 0, 0, 0);

    nmi_in = 0; repeat (3) @(negedge clk); nmi_in = 1; repeat (2) @(negedge clk);
    nmi_in = 0; repeat (3) @(negedge clk); nmi_in = 1; repeat (2) @(negedge clk);
    ctx(16'h0000, 16'h0800); boundary("R5 nmi merged", 0, 0, 0, 0, 0, 0);
    ctx(16'h0000, 16'h0800); boundary("R5 nmi single", 0, 0, 0, 0, 0, 0);

    nmi_in = 0; repeat (3) @(negedge clk); nmi_in = 1; repeat (2) @(negedge clk);
    intr_in = 1;
    ctx(16'h0300, 16'h0900); boundary("R2 prio sw", 0, 1, 8'h33, 0, 0, 8'h5C);
    ctx(16'h0300, 16'h0900); boundary("R2 prio nmi", 0, 0, 0, 0, 0, 8'h5C);
    ctx(16'h0300, 16'h0900); boundary("R2 prio intr", 0, 0, 0, 0, 0, 8'h5C);
    intr_in = 0;
    ctx(16'h0300, 16'h0900); boundary("R2 prio trap", 0, 0, 0, 0, 0, 0);

    ctx(16'h0000, 16'hFFFC); boundary("R10 iret", 1, 1, 8'h44, 0, 0, 0);

    // R2: a second strobe while busy is ignored
    ctx(16'h0000, 16'h0A00);
    cur_tag = "R2 busy ignore";
    @(negedge clk);
    insn_done = 1; sw_req = 1; sw_type = 8'h60; expect_entry(8'h60);
    @(negedge clk); insn_done = 0; sw_req = 0;
    @(negedge clk); @(negedge clk);
    insn_done = 1; sw_req = 1; sw_type = 8'h61;
    @(negedge clk); insn_done = 0; sw_req = 0;
    repeat (40) @(negedge clk);
    chk(q_addr.size() == 0 && q_uip.size() == 0, "R2 busy ignore complete", q_addr.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule